// File: doc/BRIEF.md
# CPU-to-coprocessor bus bridge

This block sits on the bus of a 16-bit host processor and lets it manage a secondary 8-bit processor. The host can stop the secondary processor and take its bus, or hand the bus back. It can hold the secondary processor in reset or release it. It can also reach the secondary processor's local RAM through an 8 KB window and set which 32 KB slice of host space the secondary processor sees. The RAM itself lies outside the block and is reached through a synchronous memory port. A read on that port returns data one cycle after the request.

Host requests arrive on a valid/ready channel. `req_ready` is tied high, so each cycle with `req_valid` high is one accepted request. Read data comes back on `rd_valid`/`rd_data` exactly one cycle after the read is accepted. There is no back-pressure on this return path, so the host must take the word in that cycle. Writes produce no response.

The bank register is filled serially, one bit per write. The bus-request status keeps reporting "busy" for a short stretch of cycles after the host takes the bus. This allows for a secondary processor that needs a few cycles to finish its current access.

Top module: `cpu_copro_bridge`

## Requirements
- R1: After reset, `sec_run`=1 (secondary processor owns its bus) and `sec_reset`=1 (held in reset). `bank_base`=0, and `periph_rst_pulse`, `drop_pulse` and `rd_valid` are 0.
- R2: A write to 0xA11100 sets `sec_run` to the inverse of bit 0 of the write byte. The write byte is `req_wdata[7:0]` when `req_word`=0 and `req_wdata[15:8]` when `req_word`=1. The host holds the bus when `sec_run`=0.
- R3: A write to 0xA11200 sets `sec_reset` to the inverse of bit 0 of the write byte, chosen as in R2. When the value changes, `periph_rst_pulse` is high for exactly one cycle. A write that leaves the value unchanged gives no pulse.
- R4: A read of 0xA11100 returns a 16-bit word. The upper byte has bit 7 set and bit 0 equal to the busy flag, and its other bits are 0. The lower byte is an 8-bit counter that starts at 0 after reset and increments after every such read, wrapping at 255. Busy is 1 whenever `sec_run`=1.
- R5: An elapsed-cycle counter is cleared in the cycle a write moves `sec_run` from 1 to 0. It then advances by one each clock and saturates at its maximum. While `sec_run`=0, busy is 1 only when that counter lies in 1..19. A status read accepted in the first cycle after the taking write therefore reports ready.
- R6: Every write to an address A with (A & 0xFF7F00) = 0xA06000 shifts the 9-bit bank register right by one and puts `req_wdata[0]` into bit 8. `bank_base` equals the register shifted left by 15.
- R7: Addresses 0xA0xxxx with address bit 14 = 0 map to the shared RAM at offset A[12:0]. A write there, made while `sec_run`=0 and `sec_reset`=0, drives one memory write. A byte write stores `req_wdata[7:0]`; a word write stores `req_wdata[15:8]`.
- R8: A shared-RAM write made while `sec_run`=1 or `sec_reset`=1 leaves memory unchanged. `drop_pulse` is then high for one cycle after the request.
- R9: A shared-RAM read returns the addressed byte in both halves of `rd_data`, whatever the bus and reset state.
- R10: A read of any address other than the status address and the shared RAM returns 0xFFFF. This includes 0xA0xxxx addresses with bit 14 = 1.
- R11: `req_ready` is always 1. `rd_valid` is high for one cycle exactly one cycle after each accepted read, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | 24 | Host byte address |
| req_wdata | input | 16 | Host write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |
| mem_addr | output | 13 | Shared RAM address |
| mem_we | output | 1 | Shared RAM write enable |
| mem_wdata | output | 8 | Shared RAM write data |
| mem_re | output | 1 | Shared RAM read enable |
| mem_rdata | input | 8 | Shared RAM read data, valid one cycle after `mem_re` |
| sec_run | output | 1 | Secondary processor owns its bus |
| sec_reset | output | 1 | Secondary processor held in reset |
| periph_rst_pulse | output | 1 | One-cycle pulse on a change of reset state |
| bank_base | output | 24 | Base address of the secondary processor's host window |
| drop_pulse | output | 1 | One-cycle pulse after a refused RAM write |

## Verification
Status reads are issued back to back for more than twenty cycles after the bus is taken. This separates the first ready cycle, the busy stretch and the final ready state, and also shows the read counter advancing. RAM writes are tried as byte and word accesses with the bus held, with the bus released and with the secondary processor in reset. Reading the same cells back afterwards shows which byte lane was stored and whether a refused write left any trace. An address that differs only above bit 12 checks the 13-bit offset. A nine-write bit pattern on two aliased bank addresses shows the shift direction and the entry point of each bit.

// File: rtl/ccb_pkg.sv
package ccb_pkg;

  // Default address map of the bridge
  localparam logic [23:0] CCB_STATUS_ADDR = 24'hA11100;
  localparam logic [23:0] CCB_HOLD_ADDR   = 24'hA11200;
  localparam logic [23:0] CCB_BANK_MATCH  = 24'hA06000;
  localparam logic [23:0] CCB_BANK_MASK   = 24'hFF7F00;
  localparam logic [7:0]  CCB_RGN_TAG     = 8'hA0;

  // Pick the byte that carries control bits for byte or word writes
  function automatic logic [7:0] ccb_lane(input logic word, input logic [15:0] wdata);
    return word ? wdata[15:8] : wdata[7:0];
  endfunction

endpackage

// File: rtl/ccb_busctl.sv
module ccb_busctl #(
  parameter int HOLD_CYC = 20,
  parameter int CNT_W    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_busreq,
  input  logic        wr_hold,
  input  logic        wbit,
  input  logic        rd_status,
  output logic        run,
  output logic        hold,
  output logic        periph_pulse,
  output logic [15:0] status
);
  localparam logic [CNT_W-1:0] GAP_MAX = '1;
  localparam logic [CNT_W-1:0] GAP_END = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] gap;
  logic [7:0]       rot;
  logic             busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run          <= 1'b1;
      hold         <= 1'b1;
      gap          <= GAP_MAX;
      rot          <= 8'h00;
      periph_pulse <= 1'b0;
    end else begin
      periph_pulse <= 1'b0;
      if (gap != GAP_MAX) gap <= gap + 1'b1;
      if (wr_busreq) begin
        run <= ~wbit;
        if (run && wbit) gap <= '0;
      end
      if (wr_hold) begin
        hold         <= ~wbit;
        periph_pulse <= (wbit == hold);
      end
      if (rd_status) rot <= rot + 8'd1;
    end
  end

  assign busy   = run || ((gap != '0) && (gap < GAP_END));
  assign status = {7'b1000000, busy, rot};

endmodule

// File: rtl/ccb_bank.sv
module ccb_bank #(
  parameter int ADDR_W    = 24,
  parameter int BANK_W    = 9,
  parameter int WIN_SHIFT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [ADDR_W-1:0] base
);
  localparam int BASE_W = BANK_W + WIN_SHIFT;

  logic [BANK_W-1:0] bank;
  logic [BASE_W-1:0] full;

  always_ff @(posedge clk) begin
    if (!rst_n)        bank <= '0;
    else if (shift_en) bank <= {bit_in, bank[BANK_W-1:1]};
  end

  assign full = {bank, {WIN_SHIFT{1'b0}}};

  generate
    if (BASE_W >= ADDR_W) begin : g_trunc
      assign base = full[ADDR_W-1:0];
    end else begin : g_ext
      assign base = {{(ADDR_W-BASE_W){1'b0}}, full};
    end
  endgenerate

endmodule

// File: rtl/ccb_ramgate.sv
module ccb_ramgate #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic          rd_hit,
  input  logic          bus_ok,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    byte_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic          mem_re,
  output logic          drop_pulse
);
  assign mem_addr  = addr_in;
  assign mem_wdata = byte_in;
  assign mem_we    = wr_hit && bus_ok;
  assign mem_re    = rd_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) drop_pulse <= 1'b0;
    else        drop_pulse <= wr_hit && !bus_ok;
  end

endmodule

// File: rtl/cpu_copro_bridge.sv
module cpu_copro_bridge
  import ccb_pkg::*;
#(
  parameter int              ADDR_W      = 24,
  parameter int              RAM_AW      = 13,
  parameter int              BANK_W      = 9,
  parameter int              WIN_SHIFT   = 15,
  parameter int              HOLD_CYC    = 20,
  parameter int              CNT_W       = 6,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = CCB_STATUS_ADDR,
  parameter logic [ADDR_W-1:0] HOLD_ADDR   = CCB_HOLD_ADDR,
  parameter logic [ADDR_W-1:0] BANK_MATCH  = CCB_BANK_MATCH,
  parameter logic [ADDR_W-1:0] BANK_MASK   = CCB_BANK_MASK,
  parameter logic [7:0]        RGN_TAG     = CCB_RGN_TAG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic [RAM_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata,
  output logic              sec_run,
  output logic              sec_reset,
  output logic              periph_rst_pulse,
  output logic [ADDR_W-1:0] bank_base,
  output logic              drop_pulse
);
  localparam int RAM_SEL_BIT = RAM_AW + 1;

  logic        fire, rd_fire, wr_fire;
  logic        in_rgn, hit_ram, hit_bank, hit_status, hit_hold;
  logic [7:0]  lane;
  logic [15:0] status;
  logic        rsp_ram;
  logic [15:0] rsp_q;

  assign req_ready = 1'b1;
  assign fire      = req_valid && req_ready;
  assign rd_fire   = fire && !req_we;
  assign wr_fire   = fire && req_we;

  assign in_rgn     = req_addr[ADDR_W-1:ADDR_W-8] == RGN_TAG;
  assign hit_ram    = in_rgn && !req_addr[RAM_SEL_BIT];
  assign hit_bank   = (req_addr & BANK_MASK) == BANK_MATCH;
  assign hit_status = req_addr == STATUS_ADDR;
  assign hit_hold   = req_addr == HOLD_ADDR;
  assign lane       = ccb_lane(req_word, req_wdata);

  ccb_busctl #(.HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)) u_busctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_busreq    (wr_fire && hit_status),
    .wr_hold      (wr_fire && hit_hold),
    .wbit         (lane[0]),
    .rd_status    (rd_fire && hit_status),
    .run          (sec_run),
    .hold         (sec_reset),
    .periph_pulse (periph_rst_pulse),
    .status       (status)
  );

  ccb_bank #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .WIN_SHIFT(WIN_SHIFT)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (wr_fire && hit_bank),
    .bit_in   (req_wdata[0]),
    .base     (bank_base)
  );

  ccb_ramgate #(.AW(RAM_AW)) u_ramgate (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hit     (wr_fire && hit_ram),
    .rd_hit     (rd_fire && hit_ram),
    .bus_ok     (!sec_run && !sec_reset),
    .addr_in    (req_addr[RAM_AW-1:0]),
    .byte_in    (lane),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .mem_re     (mem_re),
    .drop_pulse (drop_pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rsp_ram  <= 1'b0;
      rsp_q    <= 16'hFFFF;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) begin
        rsp_ram <= hit_ram;
        rsp_q   <= hit_status ? status : 16'hFFFF;
      end
    end
  end

  assign rd_data = rsp_ram ? {mem_rdata, mem_rdata} : rsp_q;

endmodule

// File: rtl/cpu_copro_bridge_chk.sv
module cpu_copro_bridge_chk #(
  parameter int                ADDR_W     = 24,
  parameter int                RAM_AW     = 13,
  parameter logic [ADDR_W-1:0] BANK_MATCH = 24'hA06000,
  parameter logic [ADDR_W-1:0] BANK_MASK  = 24'hFF7F00,
  parameter logic [7:0]        RGN_TAG    = 8'hA0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [15:0]       req_wdata,
  input logic              rd_valid,
  input logic [15:0]       rd_data,
  input logic              mem_we,
  input logic              sec_run,
  input logic              sec_reset,
  input logic              periph_rst_pulse,
  input logic [ADDR_W-1:0] bank_base
);
  logic ram_rd_req;
  assign ram_rd_req = req_valid && !req_we &&
                      (req_addr[ADDR_W-1:ADDR_W-8] == RGN_TAG) && !req_addr[RAM_AW+1];

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sec_run && sec_reset && !rd_valid && !periph_rst_pulse));

  // R11
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_we));

  // R7
  gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!sec_run && !sec_reset));

  // R3
  pulse_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_pulse |-> (sec_reset != $past(sec_reset)));

  // R6
  bank_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we && ((req_addr & BANK_MASK) == BANK_MATCH)) |=>
      (bank_base[ADDR_W-1] == $past(req_wdata[0])) &&
      (bank_base[ADDR_W-2:ADDR_W-9] == $past(bank_base[ADDR_W-1:ADDR_W-8])));

  // R9
  dup_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(ram_rd_req)) |-> (rd_data[15:8] == rd_data[7:0]));

endmodule

bind cpu_copro_bridge cpu_copro_bridge_chk #(
  .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .BANK_MATCH(BANK_MATCH),
  .BANK_MASK(BANK_MASK), .RGN_TAG(RGN_TAG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
  .rd_data(rd_data), .mem_we(mem_we), .sec_run(sec_run), .sec_reset(sec_reset),
  .periph_rst_pulse(periph_rst_pulse), .bank_base(bank_base)
);

// File: tb/test_cpu_copro_bridge.sv
`timescale 1ns/1ps
module test_cpu_copro_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, req_word = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rd_valid, mem_we, mem_re;
  logic [15:0] rd_data;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        sec_run, sec_reset, periph_rst_pulse, drop_pulse;
  logic [23:0] bank_base;

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  bmem [int];
  logic [7:0]  rot = 8'h00;
  logic [8:0]  bmodel = '0;

  always #2.5 clk = ~clk;

  cpu_copro_bridge i_cpu_copro_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata), .sec_run(sec_run),
    .sec_reset(sec_reset), .periph_rst_pulse(periph_rst_pulse), .bank_base(bank_base),
    .drop_pulse(drop_pulse)
  );

  // external RAM model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 8'h00;
    if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R11 unexpected rd_valid", {16'h0, rd_data}, 32'h0);
        else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rd_data === e, t, {16'h0, rd_data}, {16'h0, e});
        end
      end
    end
  end

  task automatic wr(input logic [23:0] a, input logic [15:0] d, input logic word);
    req_valid = 1'b1; req_we = 1'b1; req_word = word; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic rd(input logic [23:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_we = 1'b0; req_word = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bank_wr(input logic [23:0] a, input logic b);
    bmodel = {b, bmodel[8:1]};
    wr(a, {15'h0, b}, 1'b0);
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    chk(1'b0, "watchdog expired", 32'(cycles), 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(sec_run && sec_reset, "R1 run/reset after reset", {30'h0, sec_run, sec_reset}, 32'h3);
    chk(bank_base == 0 && !periph_rst_pulse && !drop_pulse && !rd_valid,
        "R1 outputs idle", {8'h0, bank_base}, 32'h0);
    chk(req_ready, "R11 ready high", {31'h0, req_ready}, 32'h1);

    // R4 status while secondary owns bus; R10 unmapped reads
    rd(24'hA11100, 16'h8100, "R4 status busy while running"); rot++;
    rd(24'hA11100, 16'h8101, "R4 status counter advances"); rot++;
    rd(24'hA06000, 16'hFFFF, "R10 bank address reads ones");
    rd(24'hA04000, 16'hFFFF, "R10 upper region reads ones");
    rd(24'h123456, 16'hFFFF, "R10 foreign address reads ones");
    idle(2);

    // R8 write refused while in reset and bus not held
    wr(24'hA00005, 16'h0077, 1'b0);
    chk(drop_pulse, "R8 drop pulse while running", {31'h0, drop_pulse}, 32'h1);
    idle(1);
    chk(!drop_pulse, "R8 drop pulse is one cycle", {31'h0, drop_pulse}, 32'h0);

    // R3 release reset with byte write, pulse once
    wr(24'hA11200, 16'h0001, 1'b0);
    chk(!sec_reset && periph_rst_pulse, "R3 release and pulse",
        {30'h0, sec_reset, periph_rst_pulse}, 32'h1);
    idle(1);
    chk(!periph_rst_pulse, "R3 pulse one cycle", {31'h0, periph_rst_pulse}, 32'h0);
    wr(24'hA11200, 16'h0100, 1'b1);
    chk(!sec_reset && !periph_rst_pulse, "R3 same value no pulse",
        {30'h0, sec_reset, periph_rst_pulse}, 32'h0);

    // R2 take bus with word write (upper byte), then R5 busy window
    wr(24'hA11100, 16'h0100, 1'b1);
    chk(!sec_run, "R2 word write takes bus", {31'h0, sec_run}, 32'h0);
    for (int k = 1; k <= 24; k++) begin
      logic busy;
      busy = (k - 1 >= 1) && (k - 1 < 20);
      rd(24'hA11100, {7'b1000000, busy, rot}, $sformatf("R5 busy window read %0d", k));
      rot++;
    end
    idle(2);

    // R7 RAM writes: byte and word lanes, 13-bit offset
    wr(24'hA00005, 16'h335A, 1'b0);
    wr(24'hA00006, 16'hC344, 1'b1);
    rd(24'hA00005, 16'h5A5A, "R7 byte write low lane / R9 dup");
    rd(24'hA00006, 16'hC3C3, "R7 word write upper lane / R9 dup");
    rd(24'hA02005, 16'h5A5A, "R7 offset uses low 13 bits");
    idle(2);

    // R2 byte write releases bus; R8 refused write leaves RAM untouched
    wr(24'hA11100, 16'h0100, 1'b0);
    chk(sec_run, "R2 byte write low lane releases bus", {31'h0, sec_run}, 32'h1);
    wr(24'hA00005, 16'h0011, 1'b0);
    chk(drop_pulse, "R8 drop when bus released", {31'h0, drop_pulse}, 32'h1);
    rd(24'hA00005, 16'h5A5A, "R8 refused write kept old byte / R9 read without bus");
    rot = rot; // counter unchanged: no status reads here
    idle(2);

    // R6 bank shift with aliased address
    bank_wr(24'hA06000, 1'b1); bank_wr(24'hA0E000, 1'b0); bank_wr(24'hA06000, 1'b1);
    bank_wr(24'hA06000, 1'b1); bank_wr(24'hA0E0FF, 1'b0); bank_wr(24'hA06000, 1'b0);
    bank_wr(24'hA06000, 1'b1); bank_wr(24'hA06000, 1'b0); bank_wr(24'hA06000, 1'b1);
    chk(bank_base == {bmodel, 15'h0}, "R6 nine-bit pattern", {8'h0, bank_base}, {8'h0, bmodel, 15'h0});
    bank_wr(24'hA06000, 1'b0);
    chk(bank_base == {bmodel, 15'h0}, "R6 extra shift", {8'h0, bank_base}, {8'h0, bmodel, 15'h0});
    wr(24'hA05000, 16'h0001, 1'b0);
    chk(bank_base == {bmodel, 15'h0}, "R6 non-bank write ignored", {8'h0, bank_base}, {8'h0, bmodel, 15'h0});

    idle(3);
    chk(exp_q.size() == 0, "R11 all reads answered", 32'(exp_q.size()), 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule